// File: doc/BRIEF.md
# Periodic Power Sample Averager

This block sits behind a measurement controller that refreshes a current register and a voltage register on a fixed cycle. For part of each cycle the register contents are not usable, and a status flag says so. The averager takes exactly one sample each time that flag goes from invalid to valid. A valid period that is seen for many clocks still adds only one sample. Each sample's current code is multiplied by its voltage code to give instantaneous power. The products are summed over a window whose length in samples is programmable.

When the window closes, a serial divider forms the mean. The block then presents the mean power code together with the number of samples that went into it, marked by a one-cycle strobe. Current codes are in steps of 0.1 A and voltage codes in steps of 0.004 V, so the power codes are in steps of 0.0004 W. With a refresh period of about 12 ms, a window of 83 samples spans roughly one second. That is long enough to smooth the slow swings in the supply readings.

A synchronous clear throws away a partly filled window. A watchdog counter raises a stale-sensor flag if no new sample arrives within a set number of clocks.

Top module: `pwr_avg_top`

## Requirements
- R1: A sample is taken only on a clock where `smp_valid` is high and was low on the previous clock. Holding `smp_valid` high for any number of clocks adds no further samples. A flag that is already high when reset is released is not counted.
- R2: Each sample's power equals the unsigned product `cur_code * volt_code` of the codes captured on the sampling clock. The product is in units of 0.0004 W.
- R3: When a window closes, `mean_pwr` becomes the floor of the summed products divided by the window's sample count, and `mean_cnt` becomes that count. `mean_vld` is high for exactly one clock with them, and both outputs hold until the next result.
- R4: A window closes on the sample that brings its count to at least the effective length. The effective length is `win_len`, or 1 when `win_len` is 0. Lowering `win_len` mid-window closes the window on the next sample.
- R5: The sum cannot overflow. Full-scale codes held for the longest window, 2^WIN_W-1 samples, produce a mean equal to the full-scale product.
- R6: A high `clr` discards the partial sum and count, any sample being captured and any division in progress. The next window starts empty.
- R7: `stale_err` rises once STALE_CYC+1 clocks pass with no sample taken. It falls on the clock after the next sample or after a `clr`.
- R8: After reset, `mean_vld`, `stale_err`, `mean_pwr` and `mean_cnt` are all zero.
- R9: `mean_vld` rises WIN_W+CUR_W+VOLT_W+1+PIPE_MUL clocks after the clock edge that took the window's last sample. The division always finishes before the next sample can close a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the current window |
| win_len | input | WIN_W | Window length in samples (0 acts as 1) |
| smp_valid | input | 1 | Status flag: register contents usable |
| cur_code | input | CUR_W | Current code, 0.1 A per step |
| volt_code | input | VOLT_W | Voltage code, 0.004 V per step |
| mean_pwr | output | CUR_W+VOLT_W | Mean power code, 0.0004 W per step |
| mean_cnt | output | WIN_W | Samples used for the mean |
| mean_vld | output | 1 | One-cycle strobe for a new result |
| stale_err | output | 1 | No sample within STALE_CYC+1 clocks |

## Verification
The bench builds the block with 6-bit current and voltage codes, a 4-bit window field, a stale limit of 200 clocks and the registered multiplier. With these values every window length from 0 to 15 can be swept. Full-scale 63×63 products can fill the longest window, which exercises the overflow bound. The 16-step divider latency is short enough to check exactly on every result. The small stale limit lets the watchdog be driven to both of its edges within a few hundred clocks.

// File: rtl/pwr_avg_pkg.sv
package pwr_avg_pkg;

   typedef enum logic {
      DIV_IDLE = 1'b0,
      DIV_RUN  = 1'b1
   } div_state_e;

   // Sum width: one product per sample, at most 2^win_w - 1 samples.
   function automatic int sum_bits(input int prod_w, input int win_w);
      return prod_w + win_w;
   endfunction

endpackage

// File: rtl/pwr_cap.sv
// Edge-qualified capture of the current and voltage codes.
module pwr_cap #(
   parameter int CUR_W  = 10,
   parameter int VOLT_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              smp_valid,
   input  logic [CUR_W-1:0]  cur_code,
   input  logic [VOLT_W-1:0] volt_code,
   output logic              cap_stb,
   output logic [CUR_W-1:0]  cap_cur,
   output logic [VOLT_W-1:0] cap_volt
);

   logic vld_prev_q;
   logic take;

   // Previous flag resets high so that a flag already up is not a fresh edge.
   assign take = smp_valid && !vld_prev_q && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_prev_q <= 1'b1;
         cap_stb    <= 1'b0;
         cap_cur    <= '0;
         cap_volt   <= '0;
      end else begin
         vld_prev_q <= smp_valid;
         cap_stb    <= take;
         if (take) begin
            cap_cur  <= cur_code;
            cap_volt <= volt_code;
         end
      end
   end

endmodule

// File: rtl/pwr_mul.sv
// Current times voltage, either registered or combinational.
module pwr_mul #(
   parameter int CUR_W    = 10,
   parameter int VOLT_W   = 12,
   parameter bit PIPE_MUL = 1'b1,
   localparam int PROD_W  = CUR_W + VOLT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              in_stb,
   input  logic [CUR_W-1:0]  in_cur,
   input  logic [VOLT_W-1:0] in_volt,
   output logic              prod_stb,
   output logic [PROD_W-1:0] prod
);

   logic [PROD_W-1:0] prod_c;

   always_comb begin
      prod_c = PROD_W'(in_cur) * PROD_W'(in_volt);
   end

   generate
      if (PIPE_MUL) begin : g_pipe
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prod_stb <= 1'b0;
               prod     <= '0;
            end else begin
               prod_stb <= in_stb && !clr;
               if (in_stb) prod <= prod_c;
            end
         end
      end else begin : g_comb
         assign prod_stb = in_stb && !clr;
         assign prod     = prod_c;
      end
   endgenerate

endmodule

// File: rtl/pwr_acc.sv
// Window sum and sample count; flags the sample that closes the window.
module pwr_acc #(
   parameter int PROD_W = 22,
   parameter int WIN_W  = 7,
   localparam int ACC_W = pwr_avg_pkg::sum_bits(PROD_W, WIN_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              prod_stb,
   input  logic [PROD_W-1:0] prod,
   input  logic [WIN_W-1:0]  win_len,
   output logic              win_done,
   output logic [ACC_W-1:0]  dividend,
   output logic [WIN_W-1:0]  divisor,
   output logic [WIN_W-1:0]  acc_cnt
);

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] next_sum;
   logic [WIN_W:0]   next_cnt;
   logic [WIN_W-1:0] eff_win;

   always_comb begin
      eff_win  = (win_len == '0) ? WIN_W'(1) : win_len;
      next_cnt = {1'b0, acc_cnt} + (WIN_W+1)'(1);
      next_sum = acc_q + ACC_W'(prod);
      win_done = prod_stb && !clr && (next_cnt >= {1'b0, eff_win});
      dividend = next_sum;
      divisor  = next_cnt[WIN_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         acc_cnt <= '0;
      end else if (clr || win_done) begin
         acc_q   <= '0;
         acc_cnt <= '0;
      end else if (prod_stb) begin
         acc_q   <= next_sum;
         acc_cnt <= next_cnt[WIN_W-1:0];
      end
   end

endmodule

// File: rtl/pwr_div.sv
// Restoring divider, one quotient bit per clock.
module pwr_div #(
   parameter int NUM_W  = 29,
   parameter int DEN_W  = 7,
   parameter int Q_W    = 22,
   localparam int STEP_W = $clog2(NUM_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             busy,
   output logic             done,
   output logic [Q_W-1:0]   quot,
   output logic [DEN_W-1:0] den_out
);

   import pwr_avg_pkg::*;

   div_state_e        state_q;
   logic [NUM_W-1:0]  quo_q;
   logic [DEN_W-1:0]  rem_q;
   logic [DEN_W-1:0]  den_q;
   logic [STEP_W-1:0] steps_q;
   logic [DEN_W:0]    rem_sh;
   logic [DEN_W:0]    rem_nx;
   logic              ge;
   logic [NUM_W-1:0]  quo_nx;

   assign busy = (state_q == DIV_RUN);

   always_comb begin
      rem_sh = {rem_q, quo_q[NUM_W-1]};
      ge     = (rem_sh >= {1'b0, den_q});
      rem_nx = ge ? (rem_sh - {1'b0, den_q}) : rem_sh;
      quo_nx = {quo_q[NUM_W-2:0], ge};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DIV_IDLE;
         quo_q   <= '0;
         rem_q   <= '0;
         den_q   <= '0;
         steps_q <= '0;
         done    <= 1'b0;
         quot    <= '0;
         den_out <= '0;
      end else begin
         done <= 1'b0;
         if (clr) begin
            state_q <= DIV_IDLE;
         end else begin
            unique case (state_q)
               DIV_IDLE: begin
                  if (start) begin
                     quo_q   <= num;
                     rem_q   <= '0;
                     den_q   <= den;
                     steps_q <= STEP_W'(NUM_W);
                     state_q <= DIV_RUN;
                  end
               end
               DIV_RUN: begin
                  quo_q   <= quo_nx;
                  rem_q   <= rem_nx[DEN_W-1:0];
                  steps_q <= steps_q - STEP_W'(1);
                  if (steps_q == STEP_W'(1)) begin
                     state_q <= DIV_IDLE;
                     done    <= 1'b1;
                     quot    <= quo_nx[Q_W-1:0];
                     den_out <= den_q;
                  end
               end
               default: state_q <= DIV_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/pwr_stale.sv
// Flags a sensor that has produced no fresh sample for too long.
module pwr_stale #(
   parameter int LIMIT = 5000000,
   localparam int CW   = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic cap_stb,
   output logic stale_err
);

   logic [CW-1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age_q     <= '0;
         stale_err <= 1'b0;
      end else if (clr || cap_stb) begin
         age_q     <= '0;
         stale_err <= 1'b0;
      end else if (age_q == CW'(LIMIT)) begin
         stale_err <= 1'b1;
      end else begin
         age_q <= age_q + CW'(1);
      end
   end

endmodule

// File: rtl/pwr_avg_top.sv
module pwr_avg_top #(
   parameter int CUR_W     = 10,
   parameter int VOLT_W    = 12,
   parameter int WIN_W     = 7,
   parameter int STALE_CYC = 5000000,
   parameter bit PIPE_MUL  = 1'b1,
   localparam int PROD_W   = CUR_W + VOLT_W,
   localparam int ACC_W    = pwr_avg_pkg::sum_bits(PROD_W, WIN_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [WIN_W-1:0]  win_len,
   input  logic              smp_valid,
   input  logic [CUR_W-1:0]  cur_code,
   input  logic [VOLT_W-1:0] volt_code,
   output logic [PROD_W-1:0] mean_pwr,
   output logic [WIN_W-1:0]  mean_cnt,
   output logic              mean_vld,
   output logic              stale_err
);

   generate
      if (CUR_W < 1 || VOLT_W < 1) begin : g_bad_codes
         $error("pwr_avg_top: code widths must be at least 1");
      end
      if (WIN_W < 1) begin : g_bad_win
         $error("pwr_avg_top: window field must be at least 1 bit");
      end
      if (STALE_CYC < 1) begin : g_bad_stale
         $error("pwr_avg_top: stale limit must be positive");
      end
   endgenerate

   logic              cap_stb;
   logic [CUR_W-1:0]  cap_cur;
   logic [VOLT_W-1:0] cap_volt;
   logic              prod_stb;
   logic [PROD_W-1:0] prod;
   logic              win_done;
   logic [ACC_W-1:0]  dividend;
   logic [WIN_W-1:0]  divisor;
   logic [WIN_W-1:0]  acc_cnt;
   logic              div_busy;

   pwr_cap #(.CUR_W(CUR_W), .VOLT_W(VOLT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .clr(clr), .smp_valid(smp_valid),
      .cur_code(cur_code), .volt_code(volt_code),
      .cap_stb(cap_stb), .cap_cur(cap_cur), .cap_volt(cap_volt)
   );

   pwr_mul #(.CUR_W(CUR_W), .VOLT_W(VOLT_W), .PIPE_MUL(PIPE_MUL)) u_mul (
      .clk(clk), .rst_n(rst_n), .clr(clr), .in_stb(cap_stb),
      .in_cur(cap_cur), .in_volt(cap_volt),
      .prod_stb(prod_stb), .prod(prod)
   );

   pwr_acc #(.PROD_W(PROD_W), .WIN_W(WIN_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(clr), .prod_stb(prod_stb), .prod(prod),
      .win_len(win_len), .win_done(win_done), .dividend(dividend),
      .divisor(divisor), .acc_cnt(acc_cnt)
   );

   pwr_div #(.NUM_W(ACC_W), .DEN_W(WIN_W), .Q_W(PROD_W)) u_div (
      .clk(clk), .rst_n(rst_n), .clr(clr), .start(win_done),
      .num(dividend), .den(divisor), .busy(div_busy), .done(mean_vld),
      .quot(mean_pwr), .den_out(mean_cnt)
   );

   pwr_stale #(.LIMIT(STALE_CYC)) u_stale (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cap_stb(cap_stb),
      .stale_err(stale_err)
   );

endmodule

// File: rtl/pwr_avg_chk.sv
module pwr_avg_chk #(
   parameter int CUR_W  = 10,
   parameter int VOLT_W = 12,
   parameter int WIN_W  = 7,
   localparam int PROD_W = CUR_W + VOLT_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr,
   input logic              smp_valid,
   input logic              mean_vld,
   input logic [WIN_W-1:0]  mean_cnt,
   input logic [PROD_W-1:0] mean_pwr,
   input logic              stale_err,
   input logic              cap_stb,
   input logic              div_busy,
   input logic              win_done,
   input logic [WIN_W-1:0]  acc_cnt
);

   localparam logic [PROD_W-1:0] FULL_PROD =
      PROD_W'(((1 << CUR_W) - 1) * ((1 << VOLT_W) - 1));

   // R1
   held_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && $past(smp_valid)) |=> !cap_stb);

   // R1
   cap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb |-> $past(smp_valid));

   // R3
   vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mean_vld |=> !mean_vld);

   // R3
   cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mean_vld |-> (mean_cnt != '0));

   // R5
   mean_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mean_vld |-> (mean_pwr <= FULL_PROD));

   // R6
   clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_cnt == '0 && !mean_vld));

   // R7
   stale_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb |=> !stale_err);

   // R9
   no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_done |-> !div_busy);

endmodule

bind pwr_avg_top pwr_avg_chk #(.CUR_W(CUR_W), .VOLT_W(VOLT_W), .WIN_W(WIN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .smp_valid(smp_valid),
   .mean_vld(mean_vld), .mean_cnt(mean_cnt), .mean_pwr(mean_pwr),
   .stale_err(stale_err), .cap_stb(cap_stb), .div_busy(div_busy),
   .win_done(win_done), .acc_cnt(acc_cnt)
);

// File: tb/tb_pwr_avg_top.sv
module tb_pwr_avg_top;

   localparam int CW    = 6;
   localparam int VW    = 6;
   localparam int WW    = 4;
   localparam int STALE = 200;
   localparam bit PIPE  = 1'b1;
   localparam int PW    = CW + VW;
   localparam int LAT   = WW + PW + 1 + int'(PIPE);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr = 1'b0;
   logic [WW-1:0] win_len = '0;
   logic          smp_valid = 1'b0;
   logic [CW-1:0] cur_code = '0;
   logic [VW-1:0] volt_code = '0;
   logic [PW-1:0] mean_pwr;
   logic [WW-1:0] mean_cnt;
   logic          mean_vld;
   logic          stale_err;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int last_rise = 0;
   int mdl_sum = 0;
   int mdl_n = 0;
   int got = 0;
   int want = 0;
   bit finished = 1'b0;
   int exp_pwr[$];
   int exp_cnt[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pwr_avg_top #(.CUR_W(CW), .VOLT_W(VW), .WIN_W(WW), .STALE_CYC(STALE),
                 .PIPE_MUL(PIPE)) dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .win_len(win_len),
      .smp_valid(smp_valid), .cur_code(cur_code), .volt_code(volt_code),
      .mean_pwr(mean_pwr), .mean_cnt(mean_cnt), .mean_vld(mean_vld),
      .stale_err(stale_err)
   );

   task automatic check(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   // One controller update: lo clocks invalid, then hi clocks valid.
   task automatic send(input int c, input int v, input int lo, input int hi);
      int eff;
      @(negedge clk);
      smp_valid = 1'b0;
      repeat (lo) @(negedge clk);
      cur_code  = CW'(c);
      volt_code = VW'(v);
      smp_valid = 1'b1;
      last_rise = cyc + 1;
      mdl_sum += c * v;
      mdl_n++;
      eff = (win_len == 0) ? 1 : int'(win_len);
      if (mdl_n >= eff) begin
         exp_pwr.push_back(mdl_sum / mdl_n);
         exp_cnt.push_back(mdl_n);
         want++;
         mdl_sum = 0;
         mdl_n = 0;
      end
      repeat (hi) @(negedge clk);
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      mdl_sum = 0;
      mdl_n = 0;
   endtask

   always @(negedge clk) begin
      if (rst_n && mean_vld) begin
         got++;
         if (exp_pwr.size() == 0) begin
            check(1'b0, "R3 unexpected result", 1, 0);
         end else begin
            int ep;
            int ec;
            ep = exp_pwr.pop_front();
            ec = exp_cnt.pop_front();
            // R2 R3: mean is floor of summed products over count
            check(int'(mean_pwr) == ep, "R3 mean power", int'(mean_pwr), ep);
            check(int'(mean_cnt) == ec, "R3 sample count", int'(mean_cnt), ec);
            // R9: fixed latency from final capture edge
            check(cyc - last_rise == LAT, "R9 latency", cyc - last_rise, LAT);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: reset state
      check(mean_vld == 1'b0, "R8 mean_vld", int'(mean_vld), 0);
      check(stale_err == 1'b0, "R8 stale_err", int'(stale_err), 0);
      check(mean_pwr == '0, "R8 mean_pwr", int'(mean_pwr), 0);
      check(mean_cnt == '0, "R8 mean_cnt", int'(mean_cnt), 0);

      // R2 R3 R4: sweep every window length with varied codes
      for (int w = 1; w < (1 << WW); w++) begin
         win_len = WW'(w);
         for (int i = 0; i < w; i++)
            send((i * 7 + w * 3) % 64, (i * 11 + w * 5 + 1) % 64, 4, 22);
      end

      // R5: full-scale codes over the longest window
      win_len = '1;
      for (int i = 0; i < (1 << WW) - 1; i++) send(63, 63, 3, 23);

      // R4: zero length behaves as one sample per window
      win_len = '0;
      send(9, 10, 5, 21);
      send(63, 1, 5, 21);

      // R4: lowering the length mid-window closes it on the next sample
      win_len = 4'd8;
      send(10, 20, 5, 21);
      send(30, 2, 5, 21);
      send(7, 7, 5, 21);
      win_len = 4'd2;
      send(1, 50, 5, 21);

      // R1: long valid periods add only one sample each
      win_len = 4'd3;
      send(12, 13, 4, 80);
      send(40, 41, 4, 80);
      send(5, 60, 4, 80);

      // R6: clear mid-window drops the partial sum
      win_len = 4'd5;
      send(63, 63, 4, 22);
      send(63, 63, 4, 22);
      send(63, 63, 4, 22);
      pulse_clr();
      for (int i = 0; i < 5; i++) send(i + 1, 2, 4, 22);

      // R7: stale flag follows the time since the last sample
      win_len = 4'd1;
      send(5, 5, 4, 150);
      check(stale_err == 1'b0, "R7 not yet stale", int'(stale_err), 0);
      repeat (100) @(negedge clk);
      check(stale_err == 1'b1, "R7 stale after limit", int'(stale_err), 1);
      send(6, 6, 4, 10);
      check(stale_err == 1'b0, "R7 cleared by sample", int'(stale_err), 0);
      @(negedge clk);
      smp_valid = 1'b0;
      repeat (250) @(negedge clk);
      check(stale_err == 1'b1, "R7 stale while invalid", int'(stale_err), 1);
      pulse_clr();
      check(stale_err == 1'b0, "R7 cleared by clr", int'(stale_err), 0);

      repeat (40) @(negedge clk);
      // R3: every expected result arrived
      check(got == want, "R3 result count", got, want);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL R3 watchdog: actual=%0d expected=%0d", got, want);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule